// File: doc/BRIEF.md
# Watchdog Timer with Overflow and Reset Pulses

This block is an 8-bit watchdog. It counts upward from a value that software loads. The counter advances on ticks from a free-running prescaler, and a 3-bit code picks one of eight divisors of the peripheral clock. Software keeps the system alive by writing zero to the counter before it passes its top value. If the counter passes its top value, the block latches a sticky flag and drives an overflow output for a fixed number of clocks.

When internal reset is enabled, the same event also drives a longer internal reset pulse. That pulse appears on one of two outputs, power-on style or manual style, chosen by a register bit. An internal reset clears the control bits but keeps the flag, so software can still see why the reset happened. The external reset input, active low, overrides everything and clears the flag.

Software uses a simple synchronous port. A write is taken on the clock edge when the write enable is high. A read returns the register that the address selects, combinationally.

Top module: `wdog_core`

## Requirements
- R1: The counter advances only while the mode bit (control bit 0) and the run bit (control bit 1) are both 1. Otherwise it holds its value, and clearing the run bit freezes the count where it stands.
- R2: Control bits 4:2 select the tick divisor. Codes 0 to 7 give 2, 64, 128, 256, 512, 1024, 4096 and 16384 clocks. While stopped, the prescaler sits at zero, so the first increment comes one full divisor after the run bit is set.
- R3: The counter counts up from the value software writes. An increment from 8'hFF wraps it to 8'h00, and that wrap is the overflow event.
- R4: A write to the counter loads the written value and wins over a tick in the same cycle. Writing 8'h00 periodically prevents overflow, and a write made while running sets the point of the next overflow.
- R5: Overflow sets the flag, bit 0 of the reset control register, in the cycle after the wrap edge. The flag stays 1 until a write puts 0 in bit 0. Writing 1 to bit 0 has no effect.
- R6: The overflow output goes high in the cycle after the wrap edge and stays high for exactly 64 clocks.
- R7: With reset-enable (reset control bit 1) set, an internal reset pulse of exactly 128 clocks starts in the same cycle as the overflow output. With the bit clear, no reset output goes high.
- R8: Reset control bit 2 picks the reset type: 0 drives the power-on output and 1 drives the manual output. The other reset output stays low.
- R9: An overflow that causes an internal reset clears the whole control register and the enable and type bits. The flag stays set. An overflow without a reset leaves the control register as written.
- R10: A low level on the external reset input clears every register and all outputs, cutting short any pulse in progress. If it overlaps an overflow edge, it wins, the flag reads 0 and no pulse appears.
- R11: Address 0 selects the control register, address 1 the counter and address 2 the reset control register. All of them read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| ext_rst_ni | input | 1 | External reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| ovf_o | output | 1 | Overflow pulse, 64 clocks |
| rst_por_o | output | 1 | Internal power-on style reset pulse, 128 clocks |
| rst_man_o | output | 1 | Internal manual style reset pulse, 128 clocks |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 64-clock overflow pulse and a 128-clock reset pulse. This lets it check the exact pulse lengths and the 128-versus-64 overlap. It reaches the slowest divisor codes by loading the counter at or just below its top value, so even the 16384 divisor overflows after one tick. It derives every expected overflow cycle from the divisor and the prescaler phase, including a counter rewrite in mid-count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // largest prescaler exponent among the clock-select codes
    localparam int unsigned PRE_MAX_LOG2 = 14;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_RSTC = 2'd2;

    // bit 0 mode, bit 1 run, bits 4:2 clock select
    typedef struct packed {
        logic [2:0] sel;
        logic       run;
        logic       mode;
    } ctrl_t;

    // bit 0 flag, bit 1 reset enable, bit 2 manual type
    typedef struct packed {
        logic man;
        logic en;
        logic flag;
    } rstc_t;

    function automatic int unsigned div_log2(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd3:    return 8;
            3'd4:    return 9;
            3'd5:    return 10;
            3'd6:    return 12;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
#(
    parameter int unsigned PRE_W = PRE_MAX_LOG2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask_tab [8];
    logic [PRE_W-1:0] mask;

    for (genvar g = 0; g < 8; g++) begin : g_mask
        assign mask_tab[g] = PRE_W'((64'd1 << div_log2(3'(g))) - 64'd1);
    end

    assign mask   = mask_tab[sel_i];
    assign tick_o = run_i && ((pre_q & mask) == mask);

    always_comb begin
        pre_d = run_i ? pre_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    // R2: a stopped prescaler restarts from zero
    p_stop_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (pre_q == '0));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned LEN = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic busy_o
);

    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trig_i)              cnt_d = CW'(LEN);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R6: a trigger always produces an active output in the next cycle
    p_trig_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_i |=> busy_o);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned OVF_LEN = 64,
    parameter int unsigned RST_LEN = 128
) (
    input  logic             clk_i,
    input  logic             ext_rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             ovf_o,
    output logic             rst_por_o,
    output logic             rst_man_o
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned RSTC_W = $bits(rstc_t);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        rstc_t            rstc;
        logic             kind;
    } state_t;

    state_t s_d, s_q;

    logic wr_ctrl, wr_cnt, wr_rstc;
    logic counting, tick, wrap, rst_trig;
    logic ovf_busy, rst_busy, rst_any;

    assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
    assign wr_cnt   = wr_en_i && (addr_i == A_CNT);
    assign wr_rstc  = wr_en_i && (addr_i == A_RSTC);
    assign counting = s_q.ctrl.mode && s_q.ctrl.run;
    assign wrap     = counting && tick && (s_q.cnt == '1) && !wr_cnt;
    assign rst_trig = wrap && s_q.rstc.en;

    wdog_prescale #(.PRE_W(PRE_MAX_LOG2)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (ext_rst_ni),
        .run_i  (counting),
        .sel_i  (s_q.ctrl.sel),
        .tick_o (tick)
    );

    wdog_pulse #(.LEN(OVF_LEN)) u_ovf_pulse (
        .clk_i  (clk_i),
        .rst_ni (ext_rst_ni),
        .trig_i (wrap),
        .busy_o (ovf_busy)
    );

    wdog_pulse #(.LEN(RST_LEN)) u_rst_pulse (
        .clk_i  (clk_i),
        .rst_ni (ext_rst_ni),
        .trig_i (rst_trig),
        .busy_o (rst_busy)
    );

    always_comb begin
        s_d = s_q;

        if (wr_cnt) begin
            s_d.cnt = wdata_i;
        end else if (counting && tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end

        if (wr_ctrl) begin
            s_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        end

        if (wr_rstc) begin
            s_d.rstc.en   = wdata_i[1];
            s_d.rstc.man  = wdata_i[2];
            s_d.rstc.flag = s_q.rstc.flag & wdata_i[0];
        end

        if (wrap) begin
            s_d.rstc.flag = 1'b1;
            if (s_q.rstc.en) begin
                s_d.kind     = s_q.rstc.man;
                s_d.ctrl     = '0;
                s_d.rstc.en  = 1'b0;
                s_d.rstc.man = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge ext_rst_ni) begin
        if (!ext_rst_ni) s_q <= '0;
        else             s_q <= s_d;
    end

    always_comb begin
        case (addr_i)
            A_CTRL:  rdata_o = CNT_W'(s_q.ctrl);
            A_CNT:   rdata_o = s_q.cnt;
            A_RSTC:  rdata_o = CNT_W'(s_q.rstc);
            default: rdata_o = '0;
        endcase
    end

    assign ovf_o     = ovf_busy;
    assign rst_por_o = rst_busy && !s_q.kind;
    assign rst_man_o = rst_busy &&  s_q.kind;
    assign rst_any   = rst_por_o || rst_man_o;

    // R1: a stopped counter holds unless software writes it
    p_hold_r1: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        (!counting && !wr_cnt) |=> $stable(s_q.cnt));

    // R3: a tick at the top value wraps to zero and raises the pulse and flag
    p_wrap_r3: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        (counting && tick && (s_q.cnt == '1) && !wr_cnt)
        |=> ((s_q.cnt == '0) && ovf_o && s_q.rstc.flag));

    // R5: the flag is only dropped by a software write of zero
    p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        (s_q.rstc.flag && !(wr_rstc && !wdata_i[0])) |=> s_q.rstc.flag);

    // R7: an internal reset starts together with the overflow pulse
    p_rst_with_ovf_r7: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        $rose(rst_any) |-> $rose(ovf_o));

    // R8: at most one reset type is driven
    p_one_type_r8: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        !(rst_por_o && rst_man_o));

    // R9: an internal reset clears control but keeps the flag
    p_ctrl_clear_r9: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
        (wrap && s_q.rstc.en) |=> ((s_q.ctrl == '0) && s_q.rstc.flag && !s_q.rstc.en));

    // R11: register widths fit the data path
    initial begin
        p_width_r11: assert (CNT_W >= CTRL_W && CNT_W >= RSTC_W);
    end

endmodule

// File: tb/test_wdog_core.sv
module test_wdog_core;
    import wdog_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ovf, por, man;

    wdog_core i_wdog_core (
        .clk_i      (clk),
        .ext_rst_ni (rst_n),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .ovf_o      (ovf),
        .rst_por_o  (por),
        .rst_man_o  (man)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // R2 divisor exponents, codes 0..7
    int lg_tab [8] = '{1, 6, 7, 8, 9, 10, 12, 14};

    typedef struct {
        int    rise;
        int    ovf_len;
        int    por_len;
        int    man_len;
        string tag;
    } exp_t;

    exp_t q[$];
    int   ep_done = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: measures each pulse episode and compares with the queue
    bit in_ep = 1'b0;
    int m_rise, m_o, m_p, m_m;
    always @(negedge clk) begin
        if (!in_ep && ovf) begin
            in_ep  = 1'b1;
            m_rise = cyc;
            m_o = 0; m_p = 0; m_m = 0;
        end
        if (in_ep) begin
            if (ovf || por || man) begin
                m_o += int'(ovf);
                m_p += int'(por);
                m_m += int'(man);
            end else begin
                exp_t e;
                in_ep = 1'b0;
                if (q.size() == 0) begin
                    check("R6 unexpected pulse", 1, 0);
                end else begin
                    e = q.pop_front();
                    check({e.tag, " rise cycle"}, m_rise, e.rise);
                    check({e.tag, " overflow length"}, m_o, e.ovf_len);
                    check({e.tag, " power-on length"}, m_p, e.por_len);
                    check({e.tag, " manual length"}, m_m, e.man_len);
                end
                ep_done++;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d, output int at);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        at = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    // R2/R4: cycle of the overflow edge given start, last counter write and phase
    function automatic int first_ovf(input int e0, input int w_at, input int s, input int lg);
        int p;
        int t1;
        p  = 1 << lg;
        t1 = e0 + p * ((w_at - e0) / p + 1);
        return t1 + (255 - s) * p;
    endfunction

    task automatic wait_eps(input int target);
        while (ep_done < target) @(negedge clk);
    endtask

    task automatic run_ovf(input int s, input int sel, input bit en, input bit mtype,
                           input string tag);
        int e0, t;
        int target;
        logic [7:0] d, cbyte;
        exp_t e;
        cbyte = {3'b000, 3'(sel), 2'b11};
        wr(A_RSTC, {5'd0, mtype, en, 1'b0}, t);
        wr(A_CNT, 8'(s), t);
        wr(A_CTRL, cbyte, e0);
        e.rise    = first_ovf(e0, e0, s, lg_tab[sel]);
        e.ovf_len = 64;
        e.por_len = (en && !mtype) ? 128 : 0;
        e.man_len = (en &&  mtype) ? 128 : 0;
        e.tag     = tag;
        target = ep_done + 1;
        q.push_back(e);
        while (!ovf) @(negedge clk);
        rd(A_CNT, d);
        check({tag, " R3 wrapped counter"}, int'(d), 0);
        wait_eps(target);
        rd(A_RSTC, d);
        check({tag, " R5 flag set"}, int'(d[0]), 1);
        rd(A_CTRL, d);
        if (en) begin
            check({tag, " R9 control cleared"}, int'(d), 0);
            rd(A_RSTC, d);
            check({tag, " R9 only flag left"}, int'(d), 1);
        end else begin
            check({tag, " R9 control kept"}, int'(d), int'(cbyte));
            wr(A_CTRL, 8'd0, t);
        end
        wr(A_RSTC, 8'd0, t);
    endtask

    initial begin
        int t, e0, w1, eps;
        logic [7:0] d, a;
        exp_t e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset values
        rd(A_CTRL, d); check("R11 control after reset", int'(d), 0);
        rd(A_CNT, d);  check("R11 counter after reset", int'(d), 0);
        rd(A_RSTC, d); check("R11 reset control after reset", int'(d), 0);
        check("R10 outputs after reset", int'({ovf, por, man}), 0);

        // R1: run without mode, then mode without run
        wr(A_CNT, 8'd5, t);
        wr(A_CTRL, 8'b0000_0010, t);
        repeat (100) @(negedge clk);
        rd(A_CNT, d); check("R1 run without mode holds", int'(d), 5);
        wr(A_CTRL, 8'b0000_0001, t);
        repeat (100) @(negedge clk);
        rd(A_CNT, d); check("R1 mode without run holds", int'(d), 5);
        wr(A_CTRL, 8'd0, t);

        // R3 R6 basic overflow, no internal reset
        run_ovf(8'hF0, 0, 1'b0, 1'b0, "R6 code0");

        // R5: writing 1 to the flag does nothing, writing 0 clears
        wr(A_RSTC, 8'd1, t);
        rd(A_RSTC, d); check("R5 write one leaves flag clear", int'(d), 0);

        // R7 R8 power-on type, code 1
        run_ovf(8'hFE, 1, 1'b1, 1'b0, "R7 power-on code1");
        // R8 manual type, code 2
        run_ovf(8'hFF, 2, 1'b1, 1'b1, "R8 manual code2");

        // R2 remaining codes
        for (int s = 3; s < 8; s++) begin
            run_ovf(8'hFF, s, 1'b0, 1'b0, $sformatf("R2 code%0d", s));
        end

        // R5 flag sticky until written with zero
        run_ovf(8'hFF, 0, 1'b0, 1'b0, "R5 sticky");
        wr(A_CTRL, 8'd0, t);

        // R4 servicing prevents overflow
        eps = ep_done;
        wr(A_CNT, 8'd0, t);
        wr(A_CTRL, 8'b0000_0011, t);
        for (int k = 0; k < 4; k++) begin
            repeat (400) @(negedge clk);
            wr(A_CNT, 8'd0, t);
        end
        rd(A_RSTC, d); check("R4 serviced flag stays clear", int'(d), 0);
        check("R4 serviced no pulse", ep_done, eps);
        wr(A_CTRL, 8'd0, t);

        // R4 rewrite in mid-count moves the overflow point
        wr(A_CNT, 8'hF0, t);
        wr(A_CTRL, 8'b0000_0011, e0);
        repeat (7) @(negedge clk);
        wr(A_CNT, 8'hF0, w1);
        e.rise = first_ovf(e0, w1, 8'hF0, lg_tab[0]);
        e.ovf_len = 64; e.por_len = 0; e.man_len = 0;
        e.tag = "R4 rewrite";
        eps = ep_done + 1;
        q.push_back(e);
        wait_eps(eps);
        wr(A_CTRL, 8'd0, t);
        wr(A_RSTC, 8'd0, t);

        // R1 clearing run freezes the count
        wr(A_CNT, 8'd0, t);
        wr(A_CTRL, 8'b0000_0011, t);
        repeat (60) @(negedge clk);
        wr(A_CTRL, 8'b0000_0001, t);
        rd(A_CNT, a);
        repeat (50) @(negedge clk);
        rd(A_CNT, d);
        check("R1 stopped count advanced before stop", int'(a != 0), 1);
        check("R1 stopped count frozen", int'(d), int'(a));
        wr(A_CTRL, 8'd0, t);

        // R10 external reset overlapping the overflow edge
        eps = ep_done;
        wr(A_RSTC, 8'h02, t);
        wr(A_CNT, 8'hFF, t);
        wr(A_CTRL, 8'b0000_0011, e0);
        @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_RSTC, d); check("R10 overlap flag cleared", int'(d), 0);
        rd(A_CTRL, d); check("R10 overlap control cleared", int'(d), 0);
        check("R10 overlap no pulse", ep_done, eps);

        // R10 external reset cuts a pulse short
        wr(A_RSTC, 8'h02, t);
        wr(A_CNT, 8'hFF, t);
        wr(A_CTRL, 8'b0000_0011, e0);
        e.rise = first_ovf(e0, e0, 8'hFF, lg_tab[0]);
        e.ovf_len = 10; e.por_len = 10; e.man_len = 0;
        e.tag = "R10 cut pulse";
        eps = ep_done + 1;
        q.push_back(e);
        while (!ovf) @(negedge clk);
        repeat (9) @(negedge clk);
        #2 rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_eps(eps);
        rd(A_RSTC, d); check("R10 flag cleared by external reset", int'(d), 0);
        check("R10 outputs low", int'({ovf, por, man}), 0);
        check("R6 queue drained", q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule